// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Alternate Functions

This block is an eight-bit general-purpose port. Every bit has a write latch. The latch drives the gate of a pull-down transistor, through an inversion, and a modelled pull-up sets the level of each pin. A bit that holds 0 pulls its pin to ground. A bit that holds 1 releases its pin, so the pin reads high unless something outside pulls it low. Software can load the whole latch in one cycle or change a single bit. It reads back either the synchronized pin levels or the latch itself; the latch is the value that read-modify-write sequences need.

Each bit also has a fixed second role for a peripheral:

| Bit | Role | Type |
|-----|------|------|
| 0 | Serial receive | Input |
| 1 | Serial transmit | Output |
| 2 | First active-low external interrupt | Input |
| 3 | Second active-low external interrupt | Input |
| 4 | First counter clock | Input |
| 5 | Second counter clock | Input |
| 6 | Active-low external memory write strobe | Output |
| 7 | Active-low external memory read strobe | Output |

An output role is combined with the latch through an AND, so the pin pulls low when either of them is 0. An input role receives the synchronized pin level. All pin levels pass through a two-flop synchronizer before software or a peripheral sees them.

Top module: `qbd_port`

## Requirements
- R1: Reset is synchronous and active low. After reset, with no external pull, every latch bit is 1, `pd_en` is 0x00, `port_rd` is 0xFF and `alt_in` is 5'b11111.
- R2: A byte write (`wr_byte_en`=1) loads `wr_byte_data` into the latch at the next clock edge. From that edge on, `latch_q` shows the written byte, and `pd_en` bit i is 1 for every bit i that was written 0.
- R3: A latch bit of 1 on a bit with no active output role gives `pd_en` bit 0. The pin then reads 1, unless `ext_pull_low` for that bit is 1, in which case it reads 0.
- R4: A bit write (`wr_bit_en`=1) sets latch bit `wr_bit_idx` to `wr_bit_val` at the next edge. It leaves the other seven bits unchanged.
- R5: When a byte write and a bit write fall in the same cycle, the byte is loaded first. The bit write then overrides the addressed bit.
- R6: `port_rd` shows the resolved pin level as it was two clock edges earlier. `latch_q` shows the latch contents and never the pin.
- R7: Output roles drive bit 1 from `alt_txd`, bit 6 from `alt_wr_n` and bit 7 from `alt_rd_n`. `pd_en` for each of these bits is 1 whenever the latch bit or the role input is 0, and it follows the role input in the same cycle.
- R8: `alt_in` is ordered {bit5, bit4, bit3, bit2, bit0} of the synchronized pin levels: second counter, first counter, second interrupt, first interrupt, receive. It has the same two-edge latency as `port_rd`.
- R9: The role inputs have no effect on bits 0, 2, 3, 4 and 5. The `pd_en` bits and pin levels of those bits depend only on the latch and `ext_pull_low`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_byte_en | input | 1 | Load the whole latch |
| wr_byte_data | input | 8 | Byte for the latch |
| wr_bit_en | input | 1 | Change one latch bit |
| wr_bit_idx | input | 3 | Index of the bit to change |
| wr_bit_val | input | 1 | Value for the addressed bit |
| alt_txd | input | 1 | Serial transmit level for bit 1 |
| alt_wr_n | input | 1 | Memory write strobe for bit 6 |
| alt_rd_n | input | 1 | Memory read strobe for bit 7 |
| ext_pull_low | input | 8 | Models an outside device pulling each pin low |
| pd_en | output | 8 | Pull-down enable for each pin |
| latch_q | output | 8 | Latch contents, for read-modify-write |
| port_rd | output | 8 | Synchronized pin levels |
| alt_in | output | 5 | Synchronized levels for the input roles |

## Verification
The bench drives several distinct patterns:

- An alternating byte (0xA5) shows that each bit reaches its own pull-down and its own read bit.
- A single-bit write over that byte shows that only the addressed bit moves.
- A byte write and a bit write in the same cycle show which one takes priority.
- An outside pull on a released bit separates the pin level from the latch contents.
- A second outside pull, checked one edge and then two edges later, pins down the synchronizer latency.
- Driving all three role inputs low shows that only bits 1, 6 and 7 respond, while the input-role bits keep reading high.

// File: rtl/qbd_pkg.sv
// Package: bit positions of the fixed alternate roles of the port.
// Assumes a port at least eight bits wide.
package qbd_pkg;
    localparam int unsigned BIT_RXD  = 0;
    localparam int unsigned BIT_TXD  = 1;
    localparam int unsigned BIT_INT0 = 2;
    localparam int unsigned BIT_INT1 = 3;
    localparam int unsigned BIT_CNT0 = 4;
    localparam int unsigned BIT_CNT1 = 5;
    localparam int unsigned BIT_WRS  = 6;
    localparam int unsigned BIT_RDS  = 7;
    localparam int unsigned ALT_IN_W = 5;
endpackage

// File: rtl/qbd_latch.sv
// Module: write latch of the port.
// It takes byte writes and single-bit writes. The bit write is applied
// after the byte write. Synchronous active-low reset loads all ones.
module qbd_latch #(
    parameter int unsigned W    = 8,
    localparam int unsigned IDXW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_en,
    input  logic [W-1:0]    byte_data,
    input  logic            bit_en,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            bit_val,
    output logic [W-1:0]    q
);
    logic [W-1:0] nxt;

    // Next latch value: byte write first, then the bit write on top.
    always_comb begin
        nxt = q;
        if (byte_en) nxt = byte_data;
        if (bit_en)  nxt[bit_idx] = bit_val;
    end

    // Latch register, released (all ones) at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= nxt;
    end
endmodule

// File: rtl/qbd_drive.sv
// Module: pull-down driver and pin resolution.
// A pin pulls low when its latch bit or its role level is 0. The modelled
// pull-up gives 1 unless the driver or an outside source pulls the pin low.
module qbd_drive #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] role_lvl,
    input  logic [W-1:0] ext_low,
    output logic [W-1:0] pd_en,
    output logic [W-1:0] pin_lvl
);
    // Gate of each pull-down: inverted AND of latch and role level.
    always_comb pd_en = ~(latch_q & role_lvl);

    // Wired-AND resolution against the pull-up.
    always_comb pin_lvl = ~(pd_en | ext_low);
endmodule

// File: rtl/qbd_sync.sv
// Module: multi-flop synchronizer for the pin levels.
// Every stage resets to all ones, the level of a released pin.
module qbd_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '1;
                else        stg[0] <= din;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/qbd_port.sv
// Module: quasi-bidirectional port with fixed alternate roles.
// It combines the write latch, the pull-down driver and the synchronizer.
// The role inputs idle high. The bit positions come from qbd_pkg.
module qbd_port #(
    parameter int unsigned W       = 8,
    parameter int unsigned SYNC_N  = 2,
    localparam int unsigned IDXW   = $clog2(W),
    localparam int unsigned AIN_W  = qbd_pkg::ALT_IN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_byte_en,
    input  logic [W-1:0]     wr_byte_data,
    input  logic             wr_bit_en,
    input  logic [IDXW-1:0]  wr_bit_idx,
    input  logic             wr_bit_val,
    input  logic             alt_txd,
    input  logic             alt_wr_n,
    input  logic             alt_rd_n,
    input  logic [W-1:0]     ext_pull_low,
    output logic [W-1:0]     pd_en,
    output logic [W-1:0]     latch_q,
    output logic [W-1:0]     port_rd,
    output logic [AIN_W-1:0] alt_in
);
    import qbd_pkg::*;

    logic [W-1:0] role_lvl;
    logic [W-1:0] pin_lvl;

    // Role levels: output roles on their bits, released (1) on all others.
    always_comb begin
        role_lvl          = '1;
        role_lvl[BIT_TXD] = alt_txd;
        role_lvl[BIT_WRS] = alt_wr_n;
        role_lvl[BIT_RDS] = alt_rd_n;
    end

    qbd_latch #(.W(W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .byte_en(wr_byte_en), .byte_data(wr_byte_data),
        .bit_en(wr_bit_en), .bit_idx(wr_bit_idx), .bit_val(wr_bit_val),
        .q(latch_q)
    );

    qbd_drive #(.W(W)) u_drive (
        .latch_q(latch_q), .role_lvl(role_lvl), .ext_low(ext_pull_low),
        .pd_en(pd_en), .pin_lvl(pin_lvl)
    );

    qbd_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_lvl), .dout(port_rd)
    );

    // Input roles tap the synchronized levels.
    always_comb alt_in = {port_rd[BIT_CNT1], port_rd[BIT_CNT0],
                          port_rd[BIT_INT1], port_rd[BIT_INT0],
                          port_rd[BIT_RXD]};
endmodule

// File: rtl/qbd_port_chk.sv
// Checker: properties of qbd_port. It is bound to the top module below.
module qbd_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_byte_en,
    input logic         wr_bit_en,
    input logic [$clog2(W)-1:0] wr_bit_idx,
    input logic         alt_txd,
    input logic [W-1:0] pd_en,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] port_rd,
    input logic [W-1:0] pin_lvl
);
    logic [1:0] since_rst;

    // Counts the edges since reset was released, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R1: reset releases every latch bit.
    a_r1_reset_release: assert property (@(posedge clk)
        !rst_n |=> latch_q == '1);

    // R2: a latch bit of 0 always has its pull-down on.
    a_r2_zero_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (~latch_q & ~pd_en) == '0);

    // R4: a lone bit write leaves the other bits unchanged.
    a_r4_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bit_en && !wr_byte_en) |=>
        ((latch_q ^ $past(latch_q)) & ~(W'(1) << $past(wr_bit_idx))) == '0);

    // R6: the read path is the pin level from two edges earlier.
    a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2) |-> port_rd == $past(pin_lvl, 2));

    // R7: a low transmit level pulls bit 1 down.
    a_r7_txd_low: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_txd |-> pd_en[1]);

    // R9: bit 0 has no output role, so a latch 1 keeps it released.
    a_r9_rxd_free: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q[0] |-> !pd_en[0]);
endmodule

bind qbd_port qbd_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_bit_en(wr_bit_en),
    .wr_bit_idx(wr_bit_idx), .alt_txd(alt_txd), .pd_en(pd_en),
    .latch_q(latch_q), .port_rd(port_rd), .pin_lvl(pin_lvl)
);

// File: tb/sim_qbd_port.sv
// Scoreboard bench for qbd_port. Driver tasks push expected items.
// A monitor compares them at the falling edge that follows.
module sim_qbd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_byte_en = 1'b0;
    logic [7:0] wr_byte_data = '0;
    logic       wr_bit_en = 1'b0;
    logic [2:0] wr_bit_idx = '0;
    logic       wr_bit_val = 1'b0;
    logic       alt_txd = 1'b1, alt_wr_n = 1'b1, alt_rd_n = 1'b1;
    logic [7:0] ext_pull_low = '0;
    logic [7:0] pd_en, latch_q, port_rd;
    logic [4:0] alt_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;   // 0 latch_q, 1 pd_en, 2 port_rd, 3 alt_in
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    qbd_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en),
        .wr_byte_data(wr_byte_data), .wr_bit_en(wr_bit_en),
        .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val),
        .alt_txd(alt_txd), .alt_wr_n(alt_wr_n), .alt_rd_n(alt_rd_n),
        .ext_pull_low(ext_pull_low), .pd_en(pd_en), .latch_q(latch_q),
        .port_rd(port_rd), .alt_in(alt_in)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input int sel, input logic [7:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: pop queued items and compare with the outputs at mid-cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sb.pop_front();
            case (it.sel)
                0: got = latch_q;
                1: got = pd_en;
                2: got = port_rd;
                default: got = {3'b000, alt_in};
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
            end
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: state after reset
        expect_item(0, 8'hFF, "R1");
        expect_item(1, 8'h00, "R1");
        expect_item(2, 8'hFF, "R1");
        expect_item(3, 8'h1F, "R1");
        step();

        // R2: byte write 0xA5
        wr_byte_en = 1'b1; wr_byte_data = 8'hA5;
        step();
        wr_byte_en = 1'b0;
        expect_item(0, 8'hA5, "R2");
        expect_item(1, 8'h5A, "R2");
        step(); step();
        expect_item(2, 8'hA5, "R6");
        step();

        // R4: set bit 1 alone
        wr_bit_en = 1'b1; wr_bit_idx = 3'd1; wr_bit_val = 1'b1;
        step();
        wr_bit_en = 1'b0;
        expect_item(0, 8'hA7, "R4");
        expect_item(1, 8'h58, "R4");
        step();

        // R5: byte 0x00 with bit 3 set in the same cycle
        wr_byte_en = 1'b1; wr_byte_data = 8'h00;
        wr_bit_en = 1'b1; wr_bit_idx = 3'd3; wr_bit_val = 1'b1;
        step();
        wr_byte_en = 1'b0; wr_bit_en = 1'b0;
        expect_item(0, 8'h08, "R5");
        step();

        // R3/R8: released port, outside pull on bit 4
        wr_byte_en = 1'b1; wr_byte_data = 8'hFF; ext_pull_low = 8'h10;
        step();
        wr_byte_en = 1'b0;
        expect_item(1, 8'h00, "R3");
        step(); step();
        expect_item(2, 8'hEF, "R3");
        expect_item(0, 8'hFF, "R6");
        expect_item(3, 8'h17, "R8");
        step();

        // R6: latency of a pin change
        ext_pull_low = 8'h01;
        step();
        expect_item(2, 8'hEF, "R6");
        step();
        expect_item(2, 8'hFE, "R6");
        expect_item(3, 8'h1E, "R8");
        ext_pull_low = 8'h00;
        step(); step(); step();

        // R7/R9: all role outputs low
        alt_txd = 1'b0; alt_wr_n = 1'b0; alt_rd_n = 1'b0;
        #0;
        expect_item(1, 8'hC2, "R7");
        step(); step(); step();
        expect_item(2, 8'h3D, "R9");
        expect_item(3, 8'h1F, "R9");
        expect_item(0, 8'hFF, "R9");
        step();
        alt_wr_n = 1'b1;
        #0;
        expect_item(1, 8'h82, "R7");
        step();
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule